// File: doc/BRIEF.md
# Tiny Floating-Point Squarer with Round-to-Nearest-Even

This block squares a positive floating-point value held in a 6-bit word. The upper three bits are a biased exponent and the lower three bits are the stored fraction. The leading significand bit is implied: it is 1 for exponent fields 001 to 110 and 0 for exponent field 000. Exponent field 000 uses the same scale as 001. The bias is a parameter.

The block forms the exact 8-bit square of the 4-bit significand and normalizes it. It then places the result in the output format and rounds to nearest, with ties going to the even value. When the result falls below the normal range, the block shifts it right into the subnormal range and collects the shifted-out bits into a sticky bit. A rounding increment can carry out of the fraction into the exponent. Results too large for the format are replaced by a reserved overflow code.

A caller presents a word with `in_valid`. The rounded result appears on `out_word` one clock later, together with a one-cycle `out_valid` pulse. The result stays on `out_word` until the next valid input.

Top module: `fsq_squarer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_word` become 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R3: For a normal result, `out_word` = {exponent field, top three bits after the leading 1} of the exact square. The exponent field is 2·(e_eff−BIAS)+BIAS, plus 1 when the product's top bit is set, with e_eff = max(e,1). The result is rounded to nearest.
- R4: When the discarded bits are exactly one half of the last kept bit, the block rounds up only if the kept fraction LSB is 1 (ties to even).
- R5: Results below 2^(1−BIAS) are output as subnormals (exponent field 000) with a value quantum of 2^(−2−BIAS). Bits shifted out during denormalization take part in the rounding as sticky bits.
- R6: A rounding increment carries from the fraction into the exponent. For example, a subnormal 000 111 that rounds up becomes 001 000 (with BIAS=8, the input 100 011 gives 001 000).
- R7: Any result whose rounded exponent field would reach 111 is output as exactly 111 000.
- R8: An input with exponent field 111 gives the output 111 000.
- R9: The zero input 000 000 gives the output 000 000.
- R10: With BIAS=8, every input with exponent field 000 or 001 gives 000 000.
- R11: `out_word` keeps its value in every cycle that follows a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | EXP_W+FRAC_W | Operand: exponent field in upper bits, stored fraction below |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_word | output | EXP_W+FRAC_W | Rounded square in the same format |

## Verification
Every one of the 64 input words is applied to two instances, one with BIAS=3 and one with BIAS=8. The expected result is computed from the exact rational square, so the sweep covers plain truncation, ties to even, sticky-decided round-ups, deep denormalization, the subnormal-to-normal carry and overflow saturation. One pass alternates valid and idle cycles to separate the pulse length and word holding from the data path. A second pass streams inputs back to back to show that consecutive results do not interfere.

// File: rtl/fsq_pkg.sv
// Shared types for the tiny float squarer.
// Assumes: operand classes are decided once, at unpack, and used downstream.
package fsq_pkg;

    // Class of an incoming operand word.
    typedef enum logic [1:0] {
        OP_ZERO = 2'd0,   // exponent and fraction both zero
        OP_SUB  = 2'd1,   // exponent field zero, fraction non-zero
        OP_NORM = 2'd2,   // ordinary normal operand
        OP_OVF  = 2'd3    // exponent field all ones (reserved overflow code)
    } op_class_e;

endpackage

// File: rtl/fsq_unpack.sv
// Splits an operand word into significand, effective exponent and class.
// Assumes: exponent field zero means hidden bit 0 at the scale of field 1.
module fsq_unpack #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 3
) (
    input  logic [EXP_W+FRAC_W-1:0] word_i,
    output logic [FRAC_W:0]         sig_o,
    output logic [EXP_W-1:0]        eff_exp_o,
    output fsq_pkg::op_class_e      cls_o
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    // Field split and hidden-bit restoration.
    always_comb begin
        exp_f     = word_i[EXP_W+FRAC_W-1:FRAC_W];
        frac_f    = word_i[FRAC_W-1:0];
        sig_o     = {(exp_f != '0), frac_f};
        eff_exp_o = (exp_f == '0) ? EXP_W'(1) : exp_f;
    end

    // Operand classification.
    always_comb begin
        if (exp_f == EXP_ONES)
            cls_o = fsq_pkg::OP_OVF;
        else if (exp_f == '0 && frac_f == '0)
            cls_o = fsq_pkg::OP_ZERO;
        else if (exp_f == '0)
            cls_o = fsq_pkg::OP_SUB;
        else
            cls_o = fsq_pkg::OP_NORM;
    end
endmodule

// File: rtl/fsq_sig_square.sv
// Exact integer square of the significand by shifted partial products.
// Assumes: SIG_W is small, so a single-cycle adder tree is acceptable.
module fsq_sig_square #(
    parameter int SIG_W = 4
) (
    input  logic [SIG_W-1:0]   sig_i,
    output logic [2*SIG_W-1:0] prod_o
);
    localparam int PROD_W = 2 * SIG_W;

    logic [PROD_W-1:0] pp [SIG_W];

    // One partial product per multiplier bit.
    for (genvar i = 0; i < SIG_W; i++) begin : g_pp
        assign pp[i] = sig_i[i] ? (PROD_W'(sig_i) << i) : '0;
    end

    // Sum of all partial products.
    always_comb begin
        prod_o = '0;
        for (int i = 0; i < SIG_W; i++)
            prod_o = prod_o + pp[i];
    end
endmodule

// File: rtl/fsq_round_pack.sv
// Normalizes the squared significand, denormalizes with sticky when needed,
// rounds to nearest even and packs the result word with overflow saturation.
// Assumes: prod_i is the exact square of the operand significand.
module fsq_round_pack #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 3,
    parameter int BIAS   = 3
) (
    input  logic [2*FRAC_W+1:0]     prod_i,
    input  logic [EXP_W-1:0]        eff_exp_i,
    input  fsq_pkg::op_class_e      cls_i,
    output logic [EXP_W+FRAC_W-1:0] word_o
);
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int LOW_W   = PROD_W - SIG_W;
    localparam int LZ_W    = $clog2(PROD_W + 1);
    localparam int SW      = EXP_W + LZ_W + 3;
    localparam int PW      = SW + FRAC_W;
    localparam int WORD_W  = EXP_W + FRAC_W;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam logic [WORD_W-1:0] OVF_WORD = WORD_W'(EXP_MAX << FRAC_W);

    logic [LZ_W-1:0]      lz;
    logic [PROD_W-1:0]    norm;
    logic signed [SW-1:0] e_res;
    logic [LZ_W-1:0]      amt;
    logic [PROD_W-1:0]    shifted;
    logic                 lost;
    logic [SIG_W-1:0]     keep;
    logic                 rbit;
    logic                 sticky;
    logic                 up;
    logic [SIG_W:0]       mant;
    logic signed [PW-1:0] wide;

    // Leading-zero count of the product (highest set bit wins).
    always_comb begin
        lz = LZ_W'(PROD_W);
        for (int i = 0; i < PROD_W; i++)
            if (prod_i[i]) lz = LZ_W'(PROD_W - 1 - i);
    end

    // Normalize and form the biased result exponent.
    always_comb begin
        norm  = prod_i << lz;
        e_res = SW'(1) + SW'(eff_exp_i) + SW'(eff_exp_i) - SW'(lz) - SW'(BIAS);
    end

    // Right-shift amount for results below the normal range.
    always_comb begin
        if (e_res >= 1)
            amt = '0;
        else if (e_res <= 1 - PROD_W)
            amt = LZ_W'(PROD_W);
        else
            amt = LZ_W'(SW'(1) - e_res);
    end

    // Denormalizing shift with sticky collection of dropped bits.
    always_comb begin
        shifted = norm >> amt;
        lost    = |(norm & ~({PROD_W{1'b1}} << amt));
        keep    = shifted[PROD_W-1 -: SIG_W];
        rbit    = shifted[LOW_W-1];
        sticky  = (|shifted[LOW_W-2:0]) | lost;
    end

    // Round to nearest, ties to even.
    always_comb begin
        up   = rbit & (sticky | keep[0]);
        mant = {1'b0, keep} + (SIG_W+1)'(up);
    end

    // Pack: carry from fraction into exponent falls out of the addition.
    always_comb begin
        wide = PW'({e_res, {FRAC_W{1'b0}}}) + PW'(mant) - PW'(1 << FRAC_W);
        unique case (cls_i)
            fsq_pkg::OP_ZERO: word_o = '0;
            fsq_pkg::OP_OVF:  word_o = OVF_WORD;
            default: begin
                if (e_res < 1)
                    word_o = WORD_W'(mant);
                else if (wide >= PW'(EXP_MAX << FRAC_W))
                    word_o = OVF_WORD;
                else
                    word_o = wide[WORD_W-1:0];
            end
        endcase
    end

    // R5: a denormalized result never keeps a set hidden bit before rounding
    always_comb begin
        if (cls_i != fsq_pkg::OP_OVF && e_res < 1)
            sub_hidden_clear_chk: assert (keep[SIG_W-1] == 1'b0);
    end
endmodule

// File: rtl/fsq_squarer.sv
// Top: squares a positive tiny float with round-to-nearest-even and
// registers the packed result with a one-cycle valid pulse.
// Assumes: operands are positive; exponent field all ones is the overflow code.
module fsq_squarer #(
    parameter int EXP_W  = 3,
    parameter int FRAC_W = 3,
    parameter int BIAS   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W-1:0] in_word,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W-1:0] out_word
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int WORD_W = EXP_W + FRAC_W;

    logic [SIG_W-1:0]   sig;
    logic [EXP_W-1:0]   eff_exp;
    fsq_pkg::op_class_e cls;
    logic [PROD_W-1:0]  prod;
    logic [WORD_W-1:0]  result;

    fsq_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
        .word_i    (in_word),
        .sig_o     (sig),
        .eff_exp_o (eff_exp),
        .cls_o     (cls)
    );

    fsq_sig_square #(.SIG_W(SIG_W)) u_square (
        .sig_i  (sig),
        .prod_o (prod)
    );

    fsq_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .BIAS(BIAS)) u_round (
        .prod_i    (prod),
        .eff_exp_i (eff_exp),
        .cls_i     (cls),
        .word_o    (result)
    );

    // Output register: pulse valid, capture the word only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= result;
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));
    // R7
    ovf_frac_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[WORD_W-1:FRAC_W] == '1) |-> out_word[FRAC_W-1:0] == '0);
    // R8
    ovf_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[WORD_W-1:FRAC_W] == '1)
        |=> out_word == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});
    // R9
    zero_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word == '0) |=> out_word == '0);
endmodule

// File: tb/test_fsq_squarer.sv
// Exhaustive bench: every 6-bit operand on a BIAS=3 and a BIAS=8 instance.
module test_fsq_squarer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [5:0] in_word = '0;
    logic       v3, v8;
    logic [5:0] w3, w8;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsq_squarer #(.EXP_W(3), .FRAC_W(3), .BIAS(3)) i_fsq_squarer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(v3), .out_word(w3)
    );

    fsq_squarer #(.EXP_W(3), .FRAC_W(3), .BIAS(8)) i_fsq_squarer_b8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(v8), .out_word(w8)
    );

    // Exact arithmetic model with requirement tag for the case exercised.
    task automatic model(input int w, input int bias, output int res, output string tag);
        int e, f, s_int, ee, p, msb, sc, eo, d, m, q, rem, half;
        bit tie, carry;
        e = w >> 3; f = w & 7;
        tie = 0; carry = 0; eo = 0;
        if (e == 7) begin res = 56; tag = "R8"; return; end
        if (w == 0) begin res = 0; tag = "R9"; return; end
        s_int = (e == 0) ? f : 8 + f;
        ee = (e == 0) ? 1 : e;
        p = s_int * s_int;
        msb = 0;
        for (int i = 0; i < 8; i++) if ((p >> i) & 1) msb = i;
        sc = 2 * ee - 2 * bias - 6;
        eo = msb + sc + bias;
        d = (eo >= 1) ? msb - 3 : -bias - 2 - sc;
        if (d <= 0) m = p << (-d);
        else begin
            q = p >> d; rem = p - (q << d); half = 1 << (d - 1);
            if (rem == half) tie = 1;
            if (rem > half || (rem == half && (q & 1))) q++;
            m = q;
        end
        if (eo >= 1) begin
            carry = (m == 16);
            res = eo * 8 + m - 8;
            if (res >= 56) res = 56;
        end else begin
            carry = (m == 8);
            res = m;
        end
        if (bias == 8 && e <= 1) tag = "R10";
        else if (res == 56) tag = "R7";
        else if (carry) tag = "R6";
        else if (tie) tag = "R4";
        else if (eo < 1) tag = "R5";
        else tag = "R3";
    endtask

    task automatic chk(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_results(input int w);
        int r; string t;
        model(w, 3, r, t);
        chk(int'(v3), 1, "R2", "bias3 valid");
        chk(int'(w3), r, t, $sformatf("bias3 in=%0d", w));
        model(w, 8, r, t);
        chk(int'(v8), 1, "R2", "bias8 valid");
        chk(int'(w8), r, t, $sformatf("bias8 in=%0d", w));
    endtask

    initial begin
        int r; string t;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(int'(v3), 0, "R1", "valid in reset");
        chk(int'(w3), 0, "R1", "word in reset");
        chk(int'(v8), 0, "R1", "valid in reset b8");
        chk(int'(w8), 0, "R1", "word in reset b8");
        rst_n = 1'b1;
        @(negedge clk);

        // Alternating sweep: result, then an idle cycle with noise on the input.
        for (int w = 0; w < 64; w++) begin
            in_valid = 1'b1; in_word = 6'(w);
            @(negedge clk);
            chk_results(w);
            in_valid = 1'b0; in_word = ~6'(w);
            @(negedge clk);
            chk(int'(v3), 0, "R2", "bias3 valid after idle");
            chk(int'(v8), 0, "R2", "bias8 valid after idle");
            model(w, 3, r, t);
            chk(int'(w3), r, "R11", "bias3 hold");
            model(w, 8, r, t);
            chk(int'(w8), r, "R11", "bias8 hold");
        end

        // Back-to-back sweep, descending order.
        in_valid = 1'b1; in_word = 6'd63;
        for (int k = 62; k >= -1; k--) begin
            @(negedge clk);
            chk_results(k + 1);
            if (k >= 0) in_word = 6'(k);
            else in_valid = 1'b0;
        end
        @(negedge clk);
        chk(int'(v3), 0, "R2", "bias3 valid after burst");
        chk(int'(v8), 0, "R2", "bias8 valid after burst");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule